// File: doc/BRIEF.md
# Privileged Hardware-Register Read Gate

This block answers reads of six hardware information registers that low-privilege code may ask for by number. The number selects one source. The sources are the CPU number, the cache-line synchronize step, a free-running cycle counter, the counter resolution, a performance counter and one configuration flag.

A per-register enable mask controls which numbers user code may read. Privileged mode lifts that restriction. Every request gets exactly one answer in the following cycle: either a data word or a reserved-instruction exception request, never both. Exception vectoring belongs to the consumer of `rsp_exc`.

The enable mask is loaded through a plain write port. The cycle counter lives inside the block, starts from zero at reset and advances on every clock.

Top module: `hwr_read_gate`

## Requirements
- R1: After reset `rsp_valid`, `rsp_exc` and `rsp_data` are all zero. The enable mask is all zero, so every user-mode read of numbers 0 to 5 is refused.
- R2: A request with `req_valid` high is sampled on a rising edge. If the number is 0 to 5 and either `priv_mode` is high or mask bit `req_idx` is set, `rsp_valid` is 1 and `rsp_exc` is 0 after that same edge.
- R3: A refused request gives `rsp_exc` = 1, `rsp_valid` = 0 and `rsp_data` = 0 after that edge.
- R4: Numbers 6 and 7 are always refused, whatever the mode and the mask.
- R5: Number 0 returns `ebase_in[9:0]`, zero-extended to 64 bits.
- R6: Number 1 returns `sync_step_in`, zero-extended to 64 bits.
- R7: Number 2 returns the 32-bit cycle counter, sign-extended to 64 bits. The counter is 0 at reset and adds 1 on every rising edge. A read returns the count held just before its sampling edge, so a request on the first edge after reset release reads 0.
- R8: Number 3 returns `cc_res_in`, zero-extended to 64 bits.
- R9: Number 4 returns `perf_in`, zero-extended to 64 bits.
- R10: Number 5 returns `config_in[13]` in bit 0, with every other bit zero.
- R11: With `mask_we` high, the mask takes `mask_wdata` on the edge. Bit n enables number n. A request sampled on that same edge still sees the previous mask.
- R12: An edge without a request leaves `rsp_valid`, `rsp_exc` and `rsp_data` at zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mask_we | input | 1 | Load enable for the read-enable mask |
| mask_wdata | input | 6 | New mask value, bit n enables number n |
| priv_mode | input | 1 | High in kernel/privileged mode, overrides the mask |
| req_valid | input | 1 | Read request strobe |
| req_idx | input | 3 | Register number requested |
| ebase_in | input | 32 | Exception-base word; CPU number in bits 9:0 |
| sync_step_in | input | 32 | Synchronize-step size |
| cc_res_in | input | 32 | Cycle-counter resolution |
| perf_in | input | 32 | Performance counter value |
| config_in | input | 32 | Configuration word; flag in bit 13 |
| rsp_valid | output | 1 | Data answer present |
| rsp_exc | output | 1 | Reserved-instruction exception request |
| rsp_data | output | 64 | Returned value, zero unless `rsp_valid` |

## Verification
Every answer is produced by one register stage. Data, exception flag and valid for a request driven before rising edge k are therefore visible after edge k. The bench drives on the falling edge and reads on the next falling edge. It fixes its expected answer at the moment it drives. At that moment the cycle count it keeps matches the value the block will sample, and the mask it models has not yet taken any write issued in the same cycle.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

  localparam int unsigned HWR_NUM = 6;
  localparam int unsigned HWR_IDX_W = 3;

  typedef enum logic [HWR_IDX_W-1:0] {
    SEL_CPU_ID  = 3'd0,
    SEL_SSTEP   = 3'd1,
    SEL_CYCLES  = 3'd2,
    SEL_CYC_RES = 3'd3,
    SEL_PERF    = 3'd4,
    SEL_CFG_BIT = 3'd5
  } hwr_sel_e;

  typedef struct packed {
    logic        valid;
    logic        exc;
    logic [63:0] data;
  } hwr_rsp_t;

endpackage

// File: rtl/hwr_mask_reg.sv
module hwr_mask_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask
);

  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we) begin
      mask_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (we) begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

endmodule

// File: rtl/hwr_cycle_ctr.sv
module hwr_cycle_ctr #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/hwr_perm_check.sv
module hwr_perm_check #(
  parameter int unsigned N     = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             priv,
  input  logic [N-1:0]     mask,
  output logic             allow
);

  logic [N-1:0] hit;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_slot
      assign hit[gi] = (idx == IDX_W'(gi)) && (priv || mask[gi]);
    end
  endgenerate

  // Numbers with no slot never set a hit bit, so they are always refused.
  assign allow = |hit;

endmodule

// File: rtl/hwr_value_sel.sv
module hwr_value_sel
  import hwr_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned CPUNUM_W = 10,
  parameter int unsigned CFG_BIT  = 13
) (
  input  logic [HWR_IDX_W-1:0] idx,
  input  logic [WORD_W-1:0]    ebase,
  input  logic [WORD_W-1:0]    sync_step,
  input  logic [WORD_W-1:0]    cycles,
  input  logic [WORD_W-1:0]    cyc_res,
  input  logic [WORD_W-1:0]    perf,
  input  logic [WORD_W-1:0]    cfg,
  output logic [XLEN-1:0]      value
);

  localparam int unsigned EXT_W = XLEN - WORD_W;

  logic [XLEN-1:0] cpu_id_x;
  logic [XLEN-1:0] cyc_x;
  logic [XLEN-1:0] cfg_x;
  logic            unused_bits;

  assign cpu_id_x    = {{(XLEN-CPUNUM_W){1'b0}}, ebase[CPUNUM_W-1:0]};
  assign cyc_x       = {{EXT_W{cycles[WORD_W-1]}}, cycles};
  assign cfg_x       = {{(XLEN-1){1'b0}}, cfg[CFG_BIT]};
  assign unused_bits = ^{ebase[WORD_W-1:CPUNUM_W], cfg};

  always_comb begin
    unique case (hwr_sel_e'(idx))
      SEL_CPU_ID:  value = cpu_id_x;
      SEL_SSTEP:   value = {{EXT_W{1'b0}}, sync_step};
      SEL_CYCLES:  value = cyc_x;
      SEL_CYC_RES: value = {{EXT_W{1'b0}}, cyc_res};
      SEL_PERF:    value = {{EXT_W{1'b0}}, perf};
      SEL_CFG_BIT: value = cfg_x;
      default:     value = '0;
    endcase
  end

endmodule

// File: rtl/hwr_read_gate.sv
module hwr_read_gate
  import hwr_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned CPUNUM_W = 10,
  parameter int unsigned CFG_BIT  = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [HWR_NUM-1:0]   mask_wdata,
  input  logic                 priv_mode,
  input  logic                 req_valid,
  input  logic [HWR_IDX_W-1:0] req_idx,
  input  logic [WORD_W-1:0]    ebase_in,
  input  logic [WORD_W-1:0]    sync_step_in,
  input  logic [WORD_W-1:0]    cc_res_in,
  input  logic [WORD_W-1:0]    perf_in,
  input  logic [WORD_W-1:0]    config_in,
  output logic                 rsp_valid,
  output logic                 rsp_exc,
  output logic [XLEN-1:0]      rsp_data
);

  logic [HWR_NUM-1:0] en_mask;
  logic [WORD_W-1:0]  cyc_count;
  logic               allow;
  logic [XLEN-1:0]    sel_value;

  logic               valid_d, valid_q;
  logic               exc_d, exc_q;
  logic [XLEN-1:0]    data_d, data_q;

  hwr_mask_reg #(.N(HWR_NUM)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mask_we),
    .wdata (mask_wdata),
    .mask  (en_mask)
  );

  hwr_cycle_ctr #(.WIDTH(WORD_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cyc_count)
  );

  hwr_perm_check #(.N(HWR_NUM), .IDX_W(HWR_IDX_W)) u_perm (
    .idx   (req_idx),
    .priv  (priv_mode),
    .mask  (en_mask),
    .allow (allow)
  );

  hwr_value_sel #(
    .XLEN(XLEN), .WORD_W(WORD_W), .CPUNUM_W(CPUNUM_W), .CFG_BIT(CFG_BIT)
  ) u_sel (
    .idx       (req_idx),
    .ebase     (ebase_in),
    .sync_step (sync_step_in),
    .cycles    (cyc_count),
    .cyc_res   (cc_res_in),
    .perf      (perf_in),
    .cfg       (config_in),
    .value     (sel_value)
  );

  always_comb begin
    valid_d = req_valid && allow;
    exc_d   = req_valid && !allow;
    data_d  = valid_d ? sel_value : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      exc_q   <= exc_d;
      data_q  <= data_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_exc   = exc_q;
  assign rsp_data  = data_q;

  // R2 / R12: one answer per request, never both kinds.
  a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid != rsp_exc));

  a_r2_priv_override: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_mode && (req_idx < HWR_IDX_W'(HWR_NUM))) |=> rsp_valid);

  a_r3_no_data_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc |-> (rsp_data == '0));

  a_r4_high_idx_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_idx >= HWR_IDX_W'(HWR_NUM))) |=> (rsp_exc && !rsp_valid));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_exc && (rsp_data == '0)));

  a_r7_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cyc_count == $past(cyc_count) + WORD_W'(1)));

endmodule

// File: tb/hwr_read_gate_bench.sv
module hwr_read_gate_bench;

  logic        clk;
  logic        rst_n;
  logic        mask_we;
  logic [5:0]  mask_wdata;
  logic        priv_mode;
  logic        req_valid;
  logic [2:0]  req_idx;
  logic [31:0] ebase_in, sync_step_in, cc_res_in, perf_in, config_in;
  logic        rsp_valid, rsp_exc;
  logic [63:0] rsp_data;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic [31:0] ref_cyc;
  logic [5:0]  m_mask;

  hwr_read_gate u_hwr_read_gate (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .priv_mode(priv_mode), .req_valid(req_valid), .req_idx(req_idx),
    .ebase_in(ebase_in), .sync_step_in(sync_step_in), .cc_res_in(cc_res_in),
    .perf_in(perf_in), .config_in(config_in),
    .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_cyc <= 32'd0;
    else        ref_cyc <= ref_cyc + 32'd1;
  end

  function automatic logic [63:0] ref_value(input logic [2:0] idx);
    case (idx)
      3'd0: return {54'd0, ebase_in[9:0]};
      3'd1: return {32'd0, sync_step_in};
      3'd2: return {{32{ref_cyc[31]}}, ref_cyc};
      3'd3: return {32'd0, cc_res_in};
      3'd4: return {32'd0, perf_in};
      3'd5: return {63'd0, config_in[13]};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic v, input logic e, input logic [63:0] d);
    n_tests++;
    if (rsp_valid !== v || rsp_exc !== e || rsp_data !== d) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b exc=%0b data=%h, expected valid=%0b exc=%0b data=%h",
               tag, rsp_valid, rsp_exc, rsp_data, v, e, d);
    end
  endtask

  // Called just after a falling edge; checks after the next falling edge.
  task automatic step(input string tag, input bit v, input logic [2:0] idx, input bit p,
                      input bit we, input logic [5:0] wd);
    logic ev, ee;
    logic [63:0] ed;
    ebase_in     = $urandom;
    sync_step_in = $urandom;
    cc_res_in    = $urandom;
    perf_in      = $urandom;
    config_in    = $urandom;
    req_valid  = v;
    req_idx    = idx;
    priv_mode  = p;
    mask_we    = we;
    mask_wdata = wd;
    ev = v && (idx <= 3'd5) && (p || m_mask[idx]);
    ee = v && !ev;
    ed = ev ? ref_value(idx) : 64'd0;
    if (we) m_mask = wd;
    @(negedge clk);
    check(tag, ev, ee, ed);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mask_we = 1'b0; mask_wdata = '0; priv_mode = 1'b0;
    req_valid = 1'b0; req_idx = '0;
    ebase_in = '0; sync_step_in = '0; cc_res_in = '0; perf_in = '0; config_in = '0;
    m_mask = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 1'b0, 1'b0, 64'd0);
    rst_n = 1'b1;
    // R7: first edge after release reads count 0
    step("R7 first cycle count", 1, 3'd2, 1, 0, 6'd0);
    // R1: mask starts empty, user reads refused
    for (int i = 0; i < 6; i++) step("R1 empty mask refuses", 1, 3'(i), 0, 0, 6'd0);
    // R12 idle
    step("R12 idle", 0, 3'd0, 1, 0, 6'd0);
    // R2 privileged override, all sources R5 R6 R7 R8 R9 R10
    step("R5 cpu number", 1, 3'd0, 1, 0, 6'd0);
    step("R6 sync step", 1, 3'd1, 1, 0, 6'd0);
    step("R7 cycle count", 1, 3'd2, 1, 0, 6'd0);
    step("R8 resolution", 1, 3'd3, 1, 0, 6'd0);
    step("R9 perf counter", 1, 3'd4, 1, 0, 6'd0);
    step("R10 config flag", 1, 3'd5, 1, 0, 6'd0);
    // R4 high numbers in privileged mode
    step("R4 idx6 privileged", 1, 3'd6, 1, 0, 6'd0);
    step("R4 idx7 privileged", 1, 3'd7, 1, 0, 6'd0);
    // R11 same-edge write uses old mask, next edge uses new
    step("R11 same edge old mask", 1, 3'd3, 0, 1, 6'b001000);
    step("R11 next edge new mask", 1, 3'd3, 0, 0, 6'd0);
    step("R3 other bit still refused", 1, 3'd4, 0, 0, 6'd0);
    step("R11 full mask", 0, 3'd0, 0, 1, 6'b111111);
    for (int i = 0; i < 8; i++) step("R2 R4 user full mask", 1, 3'(i), 0, 0, 6'd0);
    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      step("R2 R3 random", ($urandom % 4) != 0, 3'($urandom % 8), ($urandom % 3) == 0,
           ($urandom % 6) == 0, 6'($urandom));
    end
    step("R12 final idle", 0, 3'd0, 0, 0, 6'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule